// File: doc/BRIEF.md
# Flag-Generating Integer Add/Subtract Unit

This unit performs the integer add and subtract family on byte, word or doubleword operands: plain add, add with incoming carry, increment, plain subtract, subtract with incoming borrow, decrement and exchange-add. A two-bit size input chooses the operand width. Each operation yields a result and an updated status word. Six arithmetic flags are rewritten: sign, zero, carry, auxiliary carry, parity and overflow. Every other bit of the incoming status word, such as the interrupt and trap enables, is copied through untouched.

The caller presents the destination and source operands, the operation code and the current status word, then pulses the execute strobe for one cycle. On that clock edge the unit registers the result, the new status word and, for exchange-add, a second write-back value holding the original destination. When the registered status word is fed back as the next incoming status word, chained carry and borrow operations build sums and differences wider than one operand.

Top module: `addsub_flag_unit`

## Requirements
- R1: The status word places carry at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7 and overflow at bit 11. After an operation every other bit of `stat_o` equals the same bit of `flag_i`.
- R2: Operation codes 0 (add), 1 (add with carry), 2 (increment) and 6 (exchange-add) give dst + src, dst + src + C, dst + 1 and dst + src. C is bit 0 of `flag_i`. Code 7 behaves as code 0.
- R3: Operation codes 3 (subtract), 4 (subtract with borrow) and 5 (decrement) give dst - src, dst - src - C and dst - 1, modulo the operand size.
- R4: Increment and decrement set every arithmetic flag except carry, which keeps the value of bit 0 of `flag_i`.
- R5: After an add, the carry flag is the carry out of the top bit of the selected size, and the auxiliary flag is the carry out of bit 3. After a subtract, the carry flag is the borrow out of the top bit, and the auxiliary flag is the borrow out of bit 3.
- R6: The overflow flag is 1 exactly when the true signed result lies outside the signed range of the selected size, for example below -128 or above +127 for bytes.
- R7: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Result bits above the selected size are 0. Sign is the top result bit at that size. Zero is 1 when the result is 0. Parity is 1 when the low result byte holds an even number of ones.
- R8: For exchange-add, `xch_we_o` is 1 and `xch_o` is the original destination truncated to the selected size. For every other operation `xch_we_o` is 0 and `xch_o` is 0.
- R9: All outputs update on a rising clock edge at which `exec_i` is 1, and hold their values otherwise. Reset clears them all to zero.
- R10: A 16-bit add or subtract on the low halves, then a 16-bit add-with-carry or subtract-with-borrow on the high halves using the first status word as `flag_i`, gives the 32-bit sum or difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe, one cycle per operation |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand size code |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source operand |
| flag_i | input | 16 | Incoming status word |
| res_o | output | 32 | Registered result, zero-filled above the size |
| xch_o | output | 32 | Registered second write-back value (original destination) |
| xch_we_o | output | 1 | Second write-back valid |
| stat_o | output | 16 | Registered updated status word |

## Verification
Every output is due one rising edge after the cycle in which `exec_i` is high, and no output responds to the inputs between strobes. The bench changes inputs and raises the strobe on a falling edge, lets a single rising edge capture the operation, and compares result, exchange value and status word on the next falling edge. For the hold behaviour, the bench changes the operands with the strobe low, waits two further edges, and expects the earlier values to be unchanged.

// File: rtl/asu_pkg.sv
package asu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_INC  = 3'd2,
    OP_SUB  = 3'd3,
    OP_SBB  = 3'd4,
    OP_DEC  = 3'd5,
    OP_XADD = 3'd6,
    OP_RSV  = 3'd7
  } asu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSV   = 2'd3
  } asu_size_e;

  // status word bit positions, decoded by neighbouring logic
  localparam int FLAG_C = 0;
  localparam int FLAG_P = 2;
  localparam int FLAG_A = 4;
  localparam int FLAG_Z = 6;
  localparam int FLAG_S = 7;
  localparam int FLAG_O = 11;

  localparam logic [15:0] ARITH_MASK = 16'((1 << FLAG_C) | (1 << FLAG_P) | (1 << FLAG_A) |
                                           (1 << FLAG_Z) | (1 << FLAG_S) | (1 << FLAG_O));

  // number of operand widths supported: quarter, half and full data path
  localparam int NUM_LANES = 3;

  typedef struct packed {
    logic sub;     // invert source and carry-in, report borrows
    logic use_cf;  // fold incoming carry flag into the sum
    logic one;     // replace source by constant one
    logic keep_c;  // carry flag passes through
    logic xchg;    // second write-back of the old destination
  } asu_ctrl_t;

  typedef struct packed {
    logic carry;
    logic aux;
    logic ovf;
  } asu_arith_t;

endpackage

// File: rtl/asu_decode.sv
module asu_decode
  import asu_pkg::*;
(
  input  logic [2:0] op_i,
  output asu_ctrl_t  ctrl_o
);

  asu_op_e op;
  assign op = asu_op_e'(op_i);

  always_comb begin
    ctrl_o = '0;
    unique case (op)
      OP_ADC:  ctrl_o.use_cf = 1'b1;
      OP_INC:  begin ctrl_o.one = 1'b1; ctrl_o.keep_c = 1'b1; end
      OP_SUB:  ctrl_o.sub = 1'b1;
      OP_SBB:  begin ctrl_o.sub = 1'b1; ctrl_o.use_cf = 1'b1; end
      OP_DEC:  begin ctrl_o.sub = 1'b1; ctrl_o.one = 1'b1; ctrl_o.keep_c = 1'b1; end
      OP_XADD: ctrl_o.xchg = 1'b1;
      default: ctrl_o = '0;  // plain add, reserved code aliases to it
    endcase
  end

endmodule

// File: rtl/asu_adder.sv
module asu_adder
  import asu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  input  logic [1:0]    size_i,
  output logic [DW-1:0] sum_o,
  output asu_arith_t    arith_o
);

  logic [DW-1:0] bx;
  logic          cx;
  assign bx = sub_i ? ~b_i : b_i;
  assign cx = sub_i ? ~cin_i : cin_i;

  logic [DW-1:0]        lane_sum  [NUM_LANES];
  logic [NUM_LANES-1:0] lane_cout;
  logic [NUM_LANES-1:0] lane_ovf;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int W = DW >> (NUM_LANES - 1 - g);
    logic [W:0] s;
    assign s            = {1'b0, a_i[W-1:0]} + {1'b0, bx[W-1:0]} + {{W{1'b0}}, cx};
    assign lane_sum[g]  = DW'(s[W-1:0]);
    assign lane_cout[g] = s[W];
    assign lane_ovf[g]  = (a_i[W-1] == bx[W-1]) && (s[W-1] != a_i[W-1]);
  end

  logic [4:0] nib;
  assign nib = {1'b0, a_i[3:0]} + {1'b0, bx[3:0]} + {4'b0, cx};

  logic [1:0] idx;
  always_comb begin
    unique case (asu_size_e'(size_i))
      SZ_BYTE: idx = 2'd0;
      SZ_WORD: idx = 2'd1;
      default: idx = 2'd2;
    endcase
  end

  always_comb begin
    sum_o         = lane_sum[idx];
    arith_o.carry = lane_cout[idx] ^ sub_i;
    arith_o.aux   = nib[4] ^ sub_i;
    arith_o.ovf   = lane_ovf[idx];
  end

endmodule

// File: rtl/asu_flags.sv
module asu_flags
  import asu_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 16
) (
  input  logic [DW-1:0] sum_i,
  input  logic [1:0]    size_i,
  input  asu_arith_t    arith_i,
  input  logic          keep_c_i,
  input  logic [SW-1:0] flag_i,
  output logic [SW-1:0] flag_o
);

  localparam int WQ = DW / 4;
  localparam int WH = DW / 2;

  logic sign;
  always_comb begin
    unique case (asu_size_e'(size_i))
      SZ_BYTE: sign = sum_i[WQ-1];
      SZ_WORD: sign = sum_i[WH-1];
      default: sign = sum_i[DW-1];
    endcase
  end

  always_comb begin
    flag_o         = flag_i;
    flag_o[FLAG_C] = keep_c_i ? flag_i[FLAG_C] : arith_i.carry;
    flag_o[FLAG_P] = ~^sum_i[7:0];
    flag_o[FLAG_A] = arith_i.aux;
    flag_o[FLAG_Z] = (sum_i == '0);
    flag_o[FLAG_S] = sign;
    flag_o[FLAG_O] = arith_i.ovf;
  end

endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
  import asu_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_i,
  input  logic [2:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  input  logic [SW-1:0] flag_i,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] xch_o,
  output logic          xch_we_o,
  output logic [SW-1:0] stat_o
);

  localparam int WQ = DW / 4;
  localparam int WH = DW / 2;

  asu_ctrl_t  ctrl;
  asu_arith_t arith;
  logic [DW-1:0] b_op;
  logic          cin;
  logic [DW-1:0] sum;
  logic [SW-1:0] flag_nx;
  logic [DW-1:0] size_mask;

  asu_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign b_op = ctrl.one ? DW'(1) : src_i;
  assign cin  = ctrl.use_cf & flag_i[FLAG_C];

  asu_adder #(.DW(DW)) u_add (
    .a_i     (dst_i),
    .b_i     (b_op),
    .cin_i   (cin),
    .sub_i   (ctrl.sub),
    .size_i  (size_i),
    .sum_o   (sum),
    .arith_o (arith)
  );

  asu_flags #(.DW(DW), .SW(SW)) u_flg (
    .sum_i    (sum),
    .size_i   (size_i),
    .arith_i  (arith),
    .keep_c_i (ctrl.keep_c),
    .flag_i   (flag_i),
    .flag_o   (flag_nx)
  );

  always_comb begin
    unique case (asu_size_e'(size_i))
      SZ_BYTE: size_mask = (DW'(1) << WQ) - DW'(1);
      SZ_WORD: size_mask = (DW'(1) << WH) - DW'(1);
      default: size_mask = '1;
    endcase
  end

  logic [DW-1:0] res_d, res_q, xch_d, xch_q;
  logic          we_d, we_q;
  logic [SW-1:0] stat_d, stat_q;

  always_comb begin
    res_d  = res_q;
    xch_d  = xch_q;
    we_d   = we_q;
    stat_d = stat_q;
    if (exec_i) begin
      res_d  = sum;
      xch_d  = ctrl.xchg ? (dst_i & size_mask) : '0;
      we_d   = ctrl.xchg;
      stat_d = flag_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      xch_q  <= '0;
      we_q   <= 1'b0;
      stat_q <= '0;
    end else begin
      res_q  <= res_d;
      xch_q  <= xch_d;
      we_q   <= we_d;
      stat_q <= stat_d;
    end
  end

  assign res_o    = res_q;
  assign xch_o    = xch_q;
  assign xch_we_o = we_q;
  assign stat_o   = stat_q;

endmodule

// File: rtl/asu_checker.sv
module asu_checker
  import asu_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exec_i,
  input logic [2:0]    op_i,
  input logic [1:0]    size_i,
  input logic [DW-1:0] dst_i,
  input logic [DW-1:0] src_i,
  input logic [SW-1:0] flag_i,
  input logic [DW-1:0] res_o,
  input logic [DW-1:0] xch_o,
  input logic          xch_we_o,
  input logic [SW-1:0] stat_o
);

  localparam logic [SW-1:0] KEEP = ~SW'(ARITH_MASK);

  a_r1_other_bits_copied: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i |=> ((stat_o ^ $past(flag_i)) & KEEP) == '0);

  a_r4_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && (op_i == 3'd2 || op_i == 3'd5)) |=> stat_o[FLAG_C] == $past(flag_i[FLAG_C]));

  a_r5_byte_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == 3'd0 && size_i == 2'd0)
      |=> stat_o[FLAG_C] == ((9'($past(dst_i[7:0])) + 9'($past(src_i[7:0]))) > 9'd255));

  a_r7_parity: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i |=> stat_o[FLAG_P] == ~^res_o[7:0]);

  a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i |=> stat_o[FLAG_Z] == (res_o == '0));

  a_r7_byte_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && size_i == 2'd0) |=> res_o[DW-1:8] == '0);

  a_r8_xch_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i |=> xch_we_o == ($past(op_i) == 3'd6));

  a_r8_xch_value: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == 3'd6 && size_i == 2'd0) |=> xch_o == DW'($past(dst_i[7:0])));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(stat_o) && $stable(res_o) && $stable(xch_o) && $stable(xch_we_o));

endmodule

bind addsub_flag_unit asu_checker #(.DW(DW), .SW(SW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .exec_i   (exec_i),
  .op_i     (op_i),
  .size_i   (size_i),
  .dst_i    (dst_i),
  .src_i    (src_i),
  .flag_i   (flag_i),
  .res_o    (res_o),
  .xch_o    (xch_o),
  .xch_we_o (xch_we_o),
  .stat_o   (stat_o)
);

// File: tb/addsub_flag_unit_bench.sv
`timescale 1ns/1ps
module addsub_flag_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] dst_i = '0;
  logic [31:0] src_i = '0;
  logic [15:0] flag_i = '0;
  logic [31:0] res_o, xch_o;
  logic        xch_we_o;
  logic [15:0] stat_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  addsub_flag_unit u_addsub_flag_unit (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .size_i(size_i),
    .dst_i(dst_i), .src_i(src_i), .flag_i(flag_i),
    .res_o(res_o), .xch_o(xch_o), .xch_we_o(xch_we_o), .stat_o(stat_o)
  );

  // independent reference computed with wide signed integers
  function automatic void model(input logic [2:0] op, input logic [1:0] sz,
                                input logic [31:0] a, input logic [31:0] b,
                                input logic [15:0] fin,
                                output logic [31:0] r, output logic [31:0] x,
                                output logic we, output logic [15:0] fo);
    int w;
    longint mask, half, aa, bb, c, full, lo, sa, sb, sr;
    bit sub, cf, af, of, incdec;
    w      = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    mask   = (longint'(1) << w) - 1;
    half   = longint'(1) << (w - 1);
    incdec = (op == 3'd2) || (op == 3'd5);
    sub    = (op == 3'd3) || (op == 3'd4) || (op == 3'd5);
    aa     = longint'(a) & mask;
    bb     = incdec ? 1 : (longint'(b) & mask);
    c      = ((op == 3'd1) || (op == 3'd4)) ? longint'(fin[0]) : 0;
    if (sub) begin
      full = aa - bb - c;
      cf   = full < 0;
      lo   = (aa & 15) - (bb & 15) - c;
      af   = lo < 0;
    end else begin
      full = aa + bb + c;
      cf   = (full >> w) != 0;
      lo   = (aa & 15) + (bb & 15) + c;
      af   = lo > 15;
    end
    sa = (aa >= half) ? aa - 2 * half : aa;
    sb = (bb >= half) ? bb - 2 * half : bb;
    sr = sub ? (sa - sb - c) : (sa + sb + c);
    of = (sr >= half) || (sr < -half);
    r  = 32'(full & mask);
    fo     = fin;
    fo[0]  = incdec ? fin[0] : cf;
    fo[2]  = ($countones(r[7:0]) % 2) == 0;
    fo[4]  = af;
    fo[6]  = (r == 32'd0);
    fo[7]  = r[w-1];
    fo[11] = of;
    x  = (op == 3'd6) ? 32'(aa) : 32'd0;
    we = (op == 3'd6);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive on a falling edge, capture at the rising edge, sample on the next falling edge
  task automatic apply(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] fin);
    @(negedge clk);
    op_i = op; size_i = sz; dst_i = a; src_i = b; flag_i = fin; exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
  endtask

  task automatic vec(input string req, input logic [2:0] op, input logic [1:0] sz,
                     input logic [31:0] a, input logic [31:0] b, input logic [15:0] fin);
    logic [31:0] er, ex;
    logic        ew;
    logic [15:0] es;
    model(op, sz, a, b, fin, er, ex, ew, es);
    apply(op, sz, a, b, fin);
    n_chk++;
    if (res_o !== er || xch_o !== ex || xch_we_o !== ew || stat_o !== es) begin
      n_fail++;
      $display("FAIL %s op%0d sz%0d %h,%h: actual res %h xch %h we %b st %h expected res %h xch %h we %b st %h",
               req, op, sz, a, b, res_o, xch_o, xch_we_o, stat_o, er, ex, ew, es);
    end
  endtask

  task automatic t_reset;
    chk("R9", "reset res", res_o, 32'd0);
    chk("R9", "reset stat", 32'(stat_o), 32'd0);
    chk("R9", "reset xch", {xch_o[30:0], xch_we_o}, 32'd0);
  endtask

  task automatic t_examples;
    apply(3'd0, 2'd0, 32'h12, 32'h33, 16'h0);
    chk("R2", "12+33 res", res_o, 32'h45);
    chk("R5", "12+33 stat", 32'(stat_o), 32'h0000);
    apply(3'd3, 2'd0, 32'h22, 32'h44, 16'h0);
    chk("R3", "22-44 res", res_o, 32'hDE);
    chk("R5", "22-44 stat", 32'(stat_o), 32'h0095);
    apply(3'd0, 2'd0, 32'hABCDEF80, 32'h12345680, 16'h0);
    chk("R6", "80+80 byte res", res_o, 32'h0);
    chk("R6", "80+80 byte stat", 32'(stat_o), 32'h0845);
    apply(3'd0, 2'd1, 32'h7FFF, 32'h1, 16'h0);
    chk("R6", "word 7FFF+1 res", res_o, 32'h8000);
    chk("R6", "word 7FFF+1 stat", 32'(stat_o), 32'h0894);
    apply(3'd3, 2'd2, 32'h0, 32'h1, 16'h0);
    chk("R7", "dword 0-1 res", res_o, 32'hFFFFFFFF);
    chk("R7", "dword 0-1 stat", 32'(stat_o), 32'h0095);
    apply(3'd1, 2'd0, 32'hFF, 32'h0, 16'h0001);
    chk("R2", "adc FF+0+C res", res_o, 32'h0);
    chk("R2", "adc FF+0+C stat", 32'(stat_o), 32'h0055);
    apply(3'd4, 2'd0, 32'h0, 32'h0, 16'h0001);
    chk("R3", "sbb 0-0-C res", res_o, 32'hFF);
    chk("R3", "sbb 0-0-C stat", 32'(stat_o), 32'h0095);
  endtask

  task automatic t_incdec;
    apply(3'd2, 2'd0, 32'hFF, 32'h5A, 16'h0001);
    chk("R4", "inc FF res", res_o, 32'h0);
    chk("R4", "inc FF stat", 32'(stat_o), 32'h0055);
    apply(3'd5, 2'd0, 32'h80, 32'h5A, 16'h0000);
    chk("R4", "dec 80 res", res_o, 32'h7F);
    chk("R4", "dec 80 stat", 32'(stat_o), 32'h0810);
  endtask

  task automatic t_xadd;
    apply(3'd6, 2'd0, 32'h12, 32'h02, 16'h0);
    chk("R8", "xadd res", res_o, 32'h14);
    chk("R8", "xadd old dest", xch_o, 32'h12);
    chk("R8", "xadd strobe", 32'(xch_we_o), 32'd1);
    apply(3'd0, 2'd0, 32'h12, 32'h02, 16'h0);
    chk("R8", "add no exchange", {xch_o[30:0], xch_we_o}, 32'd0);
  endtask

  task automatic t_passthrough;
    apply(3'd0, 2'd0, 32'h12, 32'h33, 16'hFFFF);
    chk("R1", "other bits copied", 32'(stat_o), 32'h0000F72A);
  endtask

  task automatic t_hold;
    logic [31:0] r0;
    logic [15:0] s0;
    apply(3'd3, 2'd0, 32'h22, 32'h44, 16'h0);
    r0 = res_o; s0 = stat_o;
    op_i = 3'd0; dst_i = 32'h1; src_i = 32'h1; flag_i = 16'hFFFF;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "hold res", res_o, r0);
    chk("R9", "hold stat", 32'(stat_o), 32'(s0));
  endtask

  task automatic t_chain;
    logic [31:0] a, b, lo;
    a = 32'h1234FFFF; b = 32'h00000001;
    apply(3'd0, 2'd1, a, b, 16'h0);
    lo = res_o;
    apply(3'd1, 2'd1, a >> 16, b >> 16, stat_o);
    chk("R10", "chained add", {res_o[15:0], lo[15:0]}, a + b);
    a = 32'h00010000; b = 32'h00000001;
    apply(3'd3, 2'd1, a, b, 16'h0);
    lo = res_o;
    apply(3'd4, 2'd1, a >> 16, b >> 16, stat_o);
    chk("R10", "chained sub", {res_o[15:0], lo[15:0]}, a - b);
  endtask

  task automatic t_sweep;
    logic [31:0] edges [8];
    logic [31:0] rng;
    edges[0] = 32'h0;        edges[1] = 32'h7F;       edges[2] = 32'h80;       edges[3] = 32'hFF;
    edges[4] = 32'h7FFF;     edges[5] = 32'h8000;     edges[6] = 32'h7FFFFFFF; edges[7] = 32'hFFFFFFFF;
    for (int op = 0; op < 8; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j += 3)
            vec("R2 R3 R5 R6 R7", 3'(op), 2'(sz), edges[i], edges[j], 16'((i + j) & 1));
    rng = 32'h1ACE5EED;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      a = rng;
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      vec("R1 R4 R8", 3'(k % 8), 2'((k / 8) % 4), a, rng, rng[31:16] ^ a[15:0]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_examples();
    t_incdec();
    t_xadd();
    t_passthrough();
    t_hold();
    t_chain();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule